// File: doc/BRIEF.md
# Pixel Hit Time Stamp and Duration Front End

This block is the digital part of one pixel in a trigger-less hybrid pixel detector. It watches the discriminator output and records each hit on its own. When the signal first rises above threshold, the block latches the value of a shared 14-bit coarse time bus. A small counter in the 640 MHz domain measures a 4-bit refinement of that arrival time. While the signal stays above threshold, the block counts reference-clock cycles. When the signal falls, the pixel raises a valid flag and presents a packed hit word to the column readout. The readout accepts the word with a ready signal, and that clears the pixel.

A mode input selects one of two behaviours. In arrival mode the pixel records one hit at a time, with a 10-bit duration that saturates. In integrate mode the pixel adds the duration of every hit into a 14-bit sum and counts hits in a 10-bit counter. Both of these saturate. The pixel keeps adding while its word waits for readout. Pixels without hit data keep valid low, so readout is sparse.

The control state machine has three states:
- IDLE: no data. A hit moves it to ACTIVE. A request for a different mode is applied here and clears the counters.
- ACTIVE: the signal is above threshold. Its end moves the machine to PENDING.
- PENDING: the word is offered. An accept returns it to IDLE. In integrate mode a new hit moves it back to ACTIVE.

Top module: `pix_hit_frontend`

## Requirements
- R1: After reset, rd_valid_o is 0 and rd_word_o is all zeros.
- R2: Bits [13:0] of the word hold the coarse bus value sampled at the third clk rising edge after disc_i goes high: two synchroniser stages, then edge detection.
- R3: Bits [17:14] of the word hold 15 minus the phase_i value sampled at the clk_fast edge that detects the hit. That is the third clk_fast edge after disc_i rises. The value is the number of fast phases left until the edge where phase_i is 15.
- R4: In arrival mode (mode_i = 0), bits [27:18] hold the number of clk rising edges at which disc_i was high, and bits [41:28] are zero.
- R5: The arrival-mode duration saturates at 1023 and never wraps.
- R6: In arrival mode, a hit that arrives while a word is pending is ignored. The word stays unchanged, and no second word follows the accept.
- R7: rd_valid_o stays high with a stable word until rd_ready_i is sampled high. In the cycle after that edge, rd_valid_o is 0 and the pixel is idle.
- R8: In integrate mode (mode_i = 1), bits [41:28] hold the summed duration of all hits since the last accept. Bits [27:18] hold the hit count. The coarse and fine fields belong to the latest hit. Hits that arrive while a word is pending are still added.
- R9: In integrate mode, the summed duration saturates at 16383 and the hit count saturates at 1023.
- R10: A change of mode_i takes effect only in IDLE. Applying the change clears all counters. A word pending in the old mode keeps its old format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz-class reference clock |
| clk_fast | input | 1 | 16x fast clock, phase-locked to clk |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = arrival/duration mode, 1 = integrate/count mode |
| disc_i | input | 1 | Asynchronous discriminator output |
| coarse_i | input | 14 | Shared coarse time bus, clk domain |
| phase_i | input | 4 | Shared fast phase count, clk_fast domain, 15 on the edge that coincides with a clk edge |
| rd_ready_i | input | 1 | Column readout accepts the word |
| rd_valid_o | output | 1 | Hit word available |
| rd_word_o | output | 42 | {summed duration, duration or count, fine, coarse}, zero when not valid |

## Verification
Two cases are the hardest to reach from the ports: saturating the event counter and integrated sum in integrate mode, and placing the hit at every fast phase. The first needs more than a thousand hits that are never read out. The bench reaches it with a long loop of short pulses and a separate single pulse of more than 16383 cycles. It reaches every fast phase by waiting on the fast phase count before raising the discriminator, and it sweeps all 16 start phases. A mode request made while a word is pending is also exercised, so that the deferred application of the mode is visible in the next word's layout.

// File: rtl/pix_pkg.sv
`timescale 1ns/1ps
package pix_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_PENDING = 2'd2
    } pix_state_e;

    typedef enum logic {
        MODE_ARRIVAL   = 1'b0,
        MODE_INTEGRATE = 1'b1
    } pix_mode_e;
endpackage

// File: rtl/pix_sync_edge.sv
`timescale 1ns/1ps
// Multi-stage synchroniser; also returns the previous synchronised level.
module pix_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = chain_q[STAGES];
endmodule

// File: rtl/pix_fine_tdc.sv
`timescale 1ns/1ps
// Counts fast phases from the detected hit edge to the next reference edge.
module pix_fine_tdc #(
    parameter int FINE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              disc_i,
    input  logic [FINE_W-1:0] phase_i,
    output logic [FINE_W-1:0] fine_o
);
    localparam logic [FINE_W-1:0] LAST_PH = '1;

    logic              lvl, prev, rise;
    logic              armed_q;
    logic [FINE_W-1:0] cnt_q, fine_q;

    pix_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_fast), .rst_n(rst_n), .async_i(disc_i),
        .level_o(lvl), .prev_o(prev)
    );

    assign rise = lvl & ~prev;

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            fine_q  <= '0;
        end else if (rise) begin
            if (phase_i == LAST_PH) begin
                fine_q  <= '0;
                armed_q <= 1'b0;
            end else begin
                armed_q <= 1'b1;
                cnt_q   <= {{(FINE_W-1){1'b0}}, 1'b1};
            end
        end else if (armed_q) begin
            if (phase_i == LAST_PH) begin
                fine_q  <= cnt_q;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fine_o = fine_q;

    assert_fine_disarm_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (armed_q && phase_i == LAST_PH) |=> !armed_q);

    assert_fine_settled_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!armed_q && !rise) |=> $stable(fine_q));
endmodule

// File: rtl/pix_sat_cnt.sv
`timescale 1ns/1ps
// Up counter that stops at a run-time limit.
module pix_sat_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] value_o
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      val_q <= '0;
        else if (clr_i)                  val_q <= '0;
        else if (inc_i && val_q < limit_i) val_q <= val_q + 1'b1;
    end

    assign value_o = val_q;

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (value_o >= $past(value_o)));
endmodule

// File: rtl/pix_hit_frontend.sv
`timescale 1ns/1ps
module pix_hit_frontend #(
    parameter int COARSE_W    = 14,
    parameter int FINE_W      = 4,
    parameter int LO_W        = 10,
    parameter int HI_W        = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                   clk,
    input  logic                                   clk_fast,
    input  logic                                   rst_n,
    input  logic                                   mode_i,
    input  logic                                   disc_i,
    input  logic [COARSE_W-1:0]                    coarse_i,
    input  logic [FINE_W-1:0]                      phase_i,
    input  logic                                   rd_ready_i,
    output logic                                   rd_valid_o,
    output logic [HI_W+LO_W+FINE_W+COARSE_W-1:0]   rd_word_o
);
    import pix_pkg::*;

    localparam int WORD_W = HI_W + LO_W + FINE_W + COARSE_W;
    localparam logic [HI_W-1:0] TOT_LIMIT = {{(HI_W-LO_W){1'b0}}, {LO_W{1'b1}}};
    localparam logic [HI_W-1:0] INT_LIMIT = '1;
    localparam logic [LO_W-1:0] EV_LIMIT  = '1;

    pix_state_e state_q, state_d;
    pix_mode_e  mode_q, mode_d;

    logic disc_lvl, disc_prev, hit_rise, mode_change;
    logic dur_inc, ev_inc, cnt_clr, coarse_ld, fine_ld;
    logic [FINE_W-1:0]   fine_fast, fine_q;
    logic [COARSE_W-1:0] coarse_q;
    logic [HI_W-1:0]     dur_val, dur_limit;
    logic [LO_W-1:0]     ev_val;
    logic [HI_W-1:0]     field_hi;
    logic [LO_W-1:0]     field_lo;

    pix_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(disc_i),
        .level_o(disc_lvl), .prev_o(disc_prev)
    );

    pix_fine_tdc #(.FINE_W(FINE_W), .SYNC_STAGES(SYNC_STAGES)) u_fine (
        .clk_fast(clk_fast), .rst_n(rst_n), .disc_i(disc_i),
        .phase_i(phase_i), .fine_o(fine_fast)
    );

    assign hit_rise    = disc_lvl & ~disc_prev;
    assign mode_change = (state_q == ST_IDLE) && (pix_mode_e'(mode_i) != mode_q);
    assign mode_d      = mode_change ? pix_mode_e'(mode_i) : mode_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_ARRIVAL;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!mode_change && hit_rise) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!disc_lvl) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (rd_ready_i)
                    state_d = ST_IDLE;
                else if (hit_rise && mode_q == MODE_INTEGRATE)
                    state_d = ST_ACTIVE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Per-state control outputs
    always_comb begin
        dur_inc   = 1'b0;
        ev_inc    = 1'b0;
        cnt_clr   = 1'b0;
        coarse_ld = 1'b0;
        fine_ld   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_change) begin
                    cnt_clr = 1'b1;
                end else if (hit_rise) begin
                    dur_inc   = 1'b1;
                    ev_inc    = (mode_q == MODE_INTEGRATE);
                    coarse_ld = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (disc_lvl) dur_inc = 1'b1;
                else          fine_ld = 1'b1;
            end
            ST_PENDING: begin
                if (rd_ready_i) begin
                    cnt_clr = 1'b1;
                end else if (hit_rise && mode_q == MODE_INTEGRATE) begin
                    dur_inc   = 1'b1;
                    ev_inc    = 1'b1;
                    coarse_ld = 1'b1;
                end
            end
            default: cnt_clr = 1'b1;
        endcase
    end

    // Time stamp registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
        end else if (cnt_clr) begin
            coarse_q <= '0;
            fine_q   <= '0;
        end else begin
            if (coarse_ld) coarse_q <= coarse_i;
            if (fine_ld)   fine_q   <= fine_fast;
        end
    end

    assign dur_limit = (mode_q == MODE_INTEGRATE) ? INT_LIMIT : TOT_LIMIT;

    pix_sat_cnt #(.W(HI_W)) u_dur (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(dur_inc),
        .limit_i(dur_limit), .value_o(dur_val)
    );

    pix_sat_cnt #(.W(LO_W)) u_ev (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(ev_inc),
        .limit_i(EV_LIMIT), .value_o(ev_val)
    );

    assign field_hi   = (mode_q == MODE_INTEGRATE) ? dur_val : '0;
    assign field_lo   = (mode_q == MODE_INTEGRATE) ? ev_val : dur_val[LO_W-1:0];
    assign rd_valid_o = (state_q == ST_PENDING);
    assign rd_word_o  = rd_valid_o ? {field_hi, field_lo, fine_q, coarse_q}
                                   : {WORD_W{1'b0}};

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i && mode_q == MODE_ARRIVAL)
        |=> (rd_valid_o && $stable(rd_word_o)));

    assert_accept_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && rd_ready_i) |=> !rd_valid_o);

    assert_tot_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ARRIVAL) |-> (dur_val <= TOT_LIMIT));

    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mode_q));

    assert_coarse_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |=> $stable(coarse_q));

    assert_ignore_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PENDING && mode_q == MODE_ARRIVAL && !rd_ready_i)
        |=> (state_q == ST_PENDING));
endmodule

// File: tb/pix_hit_frontend_tb.sv
`timescale 1ns/1ps
module pix_hit_frontend_tb_top;
    logic        clk_fast = 1'b0;
    logic [3:0]  ph = 4'd0;
    logic        clk;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        disc = 1'b0;
    logic        ready = 1'b0;
    logic [13:0] coarse = 14'd5;
    logic        valid;
    logic [41:0] word;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #0.625 clk_fast = ~clk_fast;
    always @(posedge clk_fast) ph <= ph + 4'd1;
    assign clk = ~ph[3];
    always @(negedge clk) coarse <= coarse + 14'd7;

    pix_hit_frontend dut_i (
        .clk(clk), .clk_fast(clk_fast), .rst_n(rst_n), .mode_i(mode),
        .disc_i(disc), .coarse_i(coarse), .phase_i(ph),
        .rd_ready_i(ready), .rd_valid_o(valid), .rd_word_o(word)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #0.2;
    endtask

    // Raises disc at fast phase tp for n reference edges.
    task automatic hit(input int tp, input int n,
                       output logic [13:0] cexp, output logic [3:0] fexp);
        int last;
        do begin
            @(posedge clk_fast); #0.2;
        end while (ph != 4'(tp));
        disc = 1'b1;
        fexp = 4'(15 - ((tp + 2) % 16));
        cexp = '0;
        last = (n > 3) ? n : 3;
        for (int k = 1; k <= last; k++) begin
            @(posedge clk); #0.2;
            if (k == 3) cexp = coarse;
            if (k == n) disc = 1'b0;
        end
        tick(4);
    endtask

    task automatic accept(input string req);
        ready = 1'b1;
        tick(1);
        ready = 1'b0;
        chk({req, " valid low after accept"}, valid, 0);
    endtask

    task automatic chk_word(input string tag, input int hi, input int lo,
                            input logic [3:0] f, input logic [13:0] c);
        chk({tag, " valid"}, valid, 1);
        chk({tag, " field hi"}, word[41:28], hi);
        chk({tag, " field lo"}, word[27:18], lo);
        chk("R3 fine", word[17:14], f);
        chk("R2 coarse", word[13:0], c);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [13:0] c1, c2;
        logic [3:0]  f1, f2;
        int          total;

        repeat (3) @(posedge clk);
        #0.2 rst_n = 1'b1;
        tick(1);
        chk("R1 reset valid", valid, 0);
        chk("R1 reset word", word, 0);

        // R2 R3 R4 R7: sweep all fast phases with varied durations
        for (int tp = 0; tp < 16; tp++) begin
            hit(tp, 3 + (tp % 8), c1, f1);
            chk_word("R4 arrival", 0, 3 + (tp % 8), f1, c1);
            tick(2);
            chk("R7 word held", word[13:0], c1);
            accept("R7");
        end

        // R5: duration saturation
        hit(5, 1030, c1, f1);
        chk_word("R5 saturate", 0, 1023, f1, c1);
        accept("R5");

        // R6: hit while pending ignored
        hit(2, 4, c1, f1);
        hit(9, 6, c2, f2);
        chk_word("R6 ignored hit", 0, 4, f1, c1);
        accept("R6");
        tick(5);
        chk("R6 no second word", valid, 0);

        // R10: mode request while pending is deferred
        hit(7, 5, c1, f1);
        mode = 1'b1;
        tick(3);
        chk_word("R10 old format kept", 0, 5, f1, c1);
        accept("R10");
        tick(3);

        // R8: integrate accumulation across pending hits
        hit(11, 4, c1, f1);
        chk_word("R8 first hit", 4, 1, f1, c1);
        hit(0, 6, c1, f1);
        hit(13, 3, c2, f2);
        chk_word("R8 accumulated", 13, 3, f2, c2);
        accept("R8");

        // R9: integrated duration saturation
        hit(4, 16400, c1, f1);
        chk_word("R9 sum saturate", 16383, 1, f1, c1);
        accept("R9");

        // R9: hit count saturation
        total = 0;
        for (int i = 0; i < 1030; i++) begin
            hit(i % 16, 3, c1, f1);
            total += 3;
        end
        chk_word("R9 count saturate", total, 1023, f1, c1);
        accept("R9");

        // R10: back to arrival mode, counters cleared
        mode = 1'b0;
        tick(3);
        hit(6, 7, c1, f1);
        chk_word("R10 arrival after switch", 0, 7, f1, c1);
        accept("R10");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule